// File: doc/BRIEF.md
# Reload Timer Periodic Time Base

This block turns a reference clock enable into a periodic interrupt. Each `tick_i` pulse passes through two pre-dividers in series, each of which can be switched in or out: a divide-by-32 stage and after it a divide-by-8 prescaler. The resulting step enable advances a 16-bit up-counter. When the counter steps from FFFFh, it reloads from a programmable reload register, and a request flag is raised in the same clock edge. The time-base period is (65536 − reload) steps. With both dividers in use, each step costs 256 input ticks.

The request flag and its enable live in a small interrupt-source register. That register also holds a second request/enable pair, which is set by the external input `ext_req_i`. The interrupt output is high while either pair has both its flag and its enable set. Software reads and writes four registers through a simple single-cycle port. The registers are selected by `addr_i`: 0 control, 1 count, 2 reload, 3 interrupt source. The current count is also brought out on a port of its own.

Top module: `rtbase_timer`

## Requirements
- R1: After reset, the control, count, reload and interrupt-source registers all read 0000h, `count_o` is 0000h and `irq_o` is low.
- R2: With control bits 1:0 both 0 (both dividers bypassed), the count advances by one in the clock edge that samples `tick_i` high.
- R3: With control bit 0 set (divide-by-32 in use, prescaler bypassed), the count advances once per 32 input ticks.
- R4: With control bits 1:0 = 11b, the count advances once per 256 input ticks. With only bit 1 set (prescaler alone), it advances once per 8 input ticks.
- R5: A step taken while the count is FFFFh loads the reload value into the count and sets interrupt-source bit 0 in the same edge.
- R6: Once running, overflows repeat every (65536 − reload) steps.
- R7: A write to the reload register leaves the current count untouched and is applied only at the next overflow.
- R8: A write to the count register loads it directly and takes priority over a step in the same cycle.
- R9: A high `ext_req_i` sets interrupt-source bit 2 in the next edge.
- R10: `irq_o` is high exactly when (bit 0 AND bit 1) OR (bit 2 AND bit 3) of the interrupt-source register. An enable bit at 0 keeps its flag off the output.
- R11: A software write to the interrupt-source register stores data bits 3:0. A hardware set of a flag in the same cycle wins over a written 0.
- R12: The divider stage counters advance only on input ticks. Cycles without a tick change neither them nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Reference clock enable, one pulse per input tick |
| ext_req_i | input | 1 | Request pulse for the second interrupt source |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for the selected register (combinational) |
| count_o | output | 16 | Current counter value |
| irq_o | output | 1 | Interrupt request output |

## Verification
Every state change lands in the clock edge that samples the stimulus. Count steps, reloads, flag sets and register writes are all visible one edge after the input is driven. `irq_o` follows from the flags with no further register. `rdata_o` is combinational from `addr_i`. The bench therefore drives inputs on the falling edge and samples on the next falling edge, after exactly one rising edge has passed. Divider results are checked one tick before and exactly at the expected boundary.

// File: rtl/rtb_pkg.sv
`timescale 1ns/1ps
package rtb_pkg;
  typedef enum logic [1:0] {
    RTB_CTRL    = 2'd0,
    RTB_COUNT   = 2'd1,
    RTB_RELOAD  = 2'd2,
    RTB_SUBNODE = 2'd3
  } rtb_reg_e;

  // interrupt-source register, bit 3 down to bit 0
  typedef struct packed {
    logic ext_en;
    logic ext_req;
    logic ovf_en;
    logic ovf_req;
  } rtb_sub_t;
endpackage

// File: rtl/rtb_divstage.sv
`timescale 1ns/1ps
module rtb_divstage #(
  parameter int DIV = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic use_i,
  output logic tick_o
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!use_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = use_i ? (tick_i && wrap) : tick_i;
endmodule

// File: rtl/rtb_counter.sv
`timescale 1ns/1ps
module rtb_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign ovf_o = step_i && !wr_i && (cnt_q == {CNT_W{1'b1}});

  always_comb begin
    cnt_d = cnt_q;
    if (wr_i)        cnt_d = wdata_i;
    else if (ovf_o)  cnt_d = reload_i;
    else if (step_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/rtb_subnode.sv
`timescale 1ns/1ps
module rtb_subnode
  import rtb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ovf_set_i,
  input  logic       ext_set_i,
  input  logic       wr_i,
  input  logic [3:0] wdata_i,
  output rtb_sub_t   sub_o,
  output logic       irq_o
);
  rtb_sub_t sub_q, sub_d;

  always_comb begin
    sub_d = sub_q;
    if (wr_i) sub_d = rtb_sub_t'(wdata_i);
    if (ovf_set_i) sub_d.ovf_req = 1'b1;
    if (ext_set_i) sub_d.ext_req = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sub_q <= '0;
    else         sub_q <= sub_d;
  end

  assign sub_o = sub_q;
  assign irq_o = (sub_q.ovf_req && sub_q.ovf_en) || (sub_q.ext_req && sub_q.ext_en);
endmodule

// File: rtl/rtbase_timer.sv
`timescale 1ns/1ps
module rtbase_timer
  import rtb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_A  = 32,
  parameter int DIV_B  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ext_req_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              irq_o
);
  localparam int CTRL_W = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_n_sync;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_sync <= rst_meta_q;
    end
  end

  rtb_reg_e sel;
  assign sel = rtb_reg_e'(addr_i);

  logic ctrl_wr, cnt_wr, rel_wr, sub_wr;
  assign ctrl_wr = wr_en_i && (sel == RTB_CTRL);
  assign cnt_wr  = wr_en_i && (sel == RTB_COUNT);
  assign rel_wr  = wr_en_i && (sel == RTB_RELOAD);
  assign sub_wr  = wr_en_i && (sel == RTB_SUBNODE);

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  reload_q, reload_d;

  always_comb begin
    ctrl_d   = ctrl_q;
    reload_d = reload_q;
    if (ctrl_wr) ctrl_d   = wdata_i[CTRL_W-1:0];
    if (rel_wr)  reload_d = wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
    end
  end

  logic tick_a, step;

  rtb_divstage #(.DIV(DIV_A)) u_div_a (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .tick_i (tick_i),
    .use_i  (ctrl_q[0]),
    .tick_o (tick_a)
  );

  rtb_divstage #(.DIV(DIV_B)) u_div_b (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .tick_i (tick_a),
    .use_i  (ctrl_q[1]),
    .tick_o (step)
  );

  logic ovf_pulse;

  rtb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_sync),
    .step_i   (step),
    .wr_i     (cnt_wr),
    .wdata_i  (wdata_i[CNT_W-1:0]),
    .reload_i (reload_q),
    .count_o  (count_o),
    .ovf_o    (ovf_pulse)
  );

  rtb_sub_t sub_q;

  rtb_subnode u_sub (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .ovf_set_i (ovf_pulse),
    .ext_set_i (ext_req_i),
    .wr_i      (sub_wr),
    .wdata_i   (wdata_i[3:0]),
    .sub_o     (sub_q),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      RTB_CTRL:    rdata_o[CTRL_W-1:0] = ctrl_q;
      RTB_COUNT:   rdata_o[CNT_W-1:0]  = count_o;
      RTB_RELOAD:  rdata_o[CNT_W-1:0]  = reload_q;
      RTB_SUBNODE: rdata_o[3:0]        = sub_q;
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtb_checker.sv
`timescale 1ns/1ps
module rtb_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             step,
  input logic             ovf_pulse,
  input logic             cnt_wr,
  input logic             sub_wr,
  input logic             ext_req_i,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] reload_q,
  input logic [3:0]       sub_q,
  input logic             irq_o
);
  assert_ovf_at_top_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    ovf_pulse |-> (count_o == {CNT_W{1'b1}}));

  assert_ovf_sets_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    ovf_pulse |=> sub_q[0]);

  assert_reload_loaded_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    ovf_pulse |=> (count_o == $past(reload_q)));

  assert_count_holds_R12: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!step && !cnt_wr) |=> $stable(count_o));

  assert_ext_sets_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    ext_req_i |=> sub_q[2]);

  assert_irq_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(irq_o) |-> $past(ovf_pulse || ext_req_i || sub_wr));

  assert_write_loads_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cnt_wr && step) |=> !$past(ovf_pulse));
endmodule

bind rtbase_timer rtb_checker #(.CNT_W(CNT_W)) u_rtb_checker (
  .clk_i     (clk_i),
  .rst_n     (rst_n_sync),
  .step      (step),
  .ovf_pulse (ovf_pulse),
  .cnt_wr    (cnt_wr),
  .sub_wr    (sub_wr),
  .ext_req_i (ext_req_i),
  .count_o   (count_o),
  .reload_q  (reload_q),
  .sub_q     (sub_q),
  .irq_o     (irq_o)
);

// File: tb/rtbase_timer_bench.sv
`timescale 1ns/1ps
module rtbase_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        ext_req = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic [15:0] count;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_REL = 2'd2, A_SUB = 2'd3;

  always #2 clk = ~clk;

  rtbase_timer u_rtbase_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ext_req_i(ext_req),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .count_o(count), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check("R1 register reset", v, 16'h0000);
    end
    check("R1 count_o reset", count, 16'h0000);
    check("R1 irq reset", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_bypass;
    wr(A_CTRL, 16'h0000);
    wr(A_CNT, 16'h0000);
    ticks(5);
    check("R2 one step per tick", count, 16'h0005);
    repeat (10) @(negedge clk);
    check("R12 idle cycles hold count", count, 16'h0005);
  endtask

  task automatic t_dividers;
    wr(A_CTRL, 16'h0001);
    wr(A_CNT, 16'h0000);
    ticks(31);
    check("R3 31 ticks no step", count, 16'h0000);
    ticks(1);
    check("R3 32nd tick steps", count, 16'h0001);
    wr(A_CTRL, 16'h0003);
    ticks(255);
    check("R4 255 ticks no step", count, 16'h0001);
    ticks(1);
    check("R4 256th tick steps", count, 16'h0002);
    wr(A_CTRL, 16'h0002);
    ticks(7);
    check("R4 prescaler 7 ticks no step", count, 16'h0002);
    ticks(1);
    check("R4 prescaler 8th tick steps", count, 16'h0003);
    wr(A_CTRL, 16'h0000);
  endtask

  task automatic t_overflow;
    logic [15:0] v;
    wr(A_SUB, 16'h0000);
    wr(A_REL, 16'h1234);
    wr(A_CNT, 16'hFFFE);
    ticks(1);
    check("R5 count at top", count, 16'hFFFF);
    rd(A_SUB, v);
    check("R5 no flag before overflow", v, 16'h0000);
    ticks(1);
    check("R5 reload on overflow", count, 16'h1234);
    rd(A_SUB, v);
    check("R5 flag set on overflow", v, 16'h0001);
    check("R10 disabled flag keeps irq low", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_period;
    logic [15:0] v;
    wr(A_REL, 16'hFFFC);
    wr(A_CNT, 16'hFFFF);
    ticks(1);
    check("R6 first reload", count, 16'hFFFC);
    wr(A_SUB, 16'h0000);
    ticks(3);
    check("R6 three steps no overflow", count, 16'hFFFF);
    rd(A_SUB, v);
    check("R6 no flag mid-period", v, 16'h0000);
    ticks(1);
    check("R6 fourth step reloads", count, 16'hFFFC);
    rd(A_SUB, v);
    check("R6 flag after 4 steps", v, 16'h0001);
  endtask

  task automatic t_reload_defer;
    wr(A_CNT, 16'h0010);
    wr(A_REL, 16'hAAAA);
    check("R7 reload write leaves count", count, 16'h0010);
    ticks(1);
    check("R7 counting continues", count, 16'h0011);
    wr(A_CNT, 16'hFFFF);
    ticks(1);
    check("R7 new reload at overflow", count, 16'hAAAA);
  endtask

  task automatic t_count_write;
    wr(A_CNT, 16'h0100);
    check("R8 direct load", count, 16'h0100);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = A_CNT; wdata = 16'h5555;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    check("R8 write beats step", count, 16'h5555);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    wr(A_SUB, 16'h0002);
    wr(A_CNT, 16'hFFFF);
    ticks(1);
    check("R10 enabled overflow raises irq", {15'b0, irq}, 16'h0001);
    wr(A_SUB, 16'h0002);
    check("R11 written 0 clears flag", {15'b0, irq}, 16'h0000);
    @(negedge clk); ext_req = 1'b1;
    @(negedge clk); ext_req = 1'b0;
    rd(A_SUB, v);
    check("R9 ext request sets bit 2", v, 16'h0006);
    check("R10 ext disabled irq low", {15'b0, irq}, 16'h0000);
    wr(A_SUB, 16'h000C);
    check("R10 ext enabled irq high", {15'b0, irq}, 16'h0001);
    wr(A_SUB, 16'h0000);
    check("R11 clear all irq low", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_priority;
    logic [15:0] v;
    wr(A_CNT, 16'hFFFF);
    @(negedge clk); tick = 1'b1; ext_req = 1'b1; wr_en = 1'b1; addr = A_SUB; wdata = 16'h0000;
    @(negedge clk); tick = 1'b0; ext_req = 1'b0; wr_en = 1'b0;
    rd(A_SUB, v);
    check("R11 hardware set beats written 0", v, 16'h0005);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bypass();
    t_dividers();
    t_overflow();
    t_period();
    t_reload_defer();
    t_count_write();
    t_irq();
    t_priority();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule